// File: doc/BRIEF.md
# I2C Target Controller with Clock-Stretch Event Flags

This block is the target (slave) side of an I2C bus for a local processor. It takes the raw SCL and SDA levels, passes them through a synchronizer, and finds START, STOP and clock edges. It drives each line only through an active-high "pull low" enable, so the pad behaves as open drain. When a 7-bit address matches the programmed address, the target raises an address/stop event flag. It then receives bytes from the controller or sends bytes to it, depending on the R/W bit.

Whenever the data flag or the address/stop flag is pending, the target holds SCL low. This stretches the bus clock until local software has dealt with the event. Software ends the stretch in one of two ways. It can write a one to the flag's clear strobe. It can also issue a command, which clears both event flags and, in the same cycle, chooses whether the next acknowledge slot carries ACK or NACK, or whether the next byte is sent. A status output reports the clock hold. Other status outputs give the last acknowledge bit received from the controller, the transfer direction, and a collision flag. The collision flag rises when a bit that the target released is seen low on the bus. From then until the next START, the target drives nothing on SDA.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, neither line is driven low, and the data, address/stop, collision, direction, received-acknowledge and hold outputs are all 0.
- R2: The target samples the 8 bits after a START MSB first. If bits 7..1 equal `own_addr_i`, it sets the address/stop flag after the falling edge of the 8th bit. If they do not match, no flag is set and the acknowledge slot is left released, so the controller reads 1.
- R3: `dir_o` takes bit 0 of a matching address byte (1 = controller reads, 0 = controller writes) and changes at no other time.
- R4: `scl_low_o` and `hold_o` are 1 exactly while the data flag or the address/stop flag is set. SCL on the bus stays low during that time even when the controller releases it.
- R5: A write of `cmd_i` = 2'b11 or 2'b10 with `cmd_wr_i` clears both the data flag and the address/stop flag. 2'b11 drives ACK (SDA low) in the pending acknowledge slot, or starts sending `tx_data_i` while the controller is reading. 2'b10 leaves SDA released (NACK) and stops taking part in the transfer. 2'b00 and 2'b01 have no effect.
- R6: In a controller write, each data byte is shifted in MSB first. After the falling edge of its 8th bit, the byte appears on `rx_data_o` and the data flag is set, unless a collision is pending.
- R7: In a controller read, `tx_data_i` is sent MSB first: a 0 bit is driven low and a 1 bit is released. If the controller ACKs, the data flag is set after the acknowledge slot. If it NACKs, no flag is set and SDA is not driven again.
- R8: `rxack_o` holds the acknowledge bit last sampled from the controller after a transmitted byte (0 = ACK, 1 = NACK).
- R9: A pulse on `clr_data_i`, `clr_as_i` or `clr_coll_i` clears the matching flag. Clearing the data flag or the address/stop flag this way releases SCL.
- R10: If a bit the target released (a 1 data bit, or a NACK) is sampled low on SCL rising, the collision flag and the address/stop flag are set. No low value is driven on SDA again until the next START.
- R11: A START or repeated START clears the collision flag and restarts address reception.
- R12: A STOP after the target has been addressed sets the address/stop flag when `stop_ie_i` is 1, and leaves it clear when `stop_ie_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| scl_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Pull SDA low |
| own_addr_i | input | DATA_W-1 | Target address to match |
| stop_ie_i | input | 1 | Let a STOP raise the address/stop flag |
| tx_data_i | input | DATA_W | Byte to send when the controller reads |
| rx_data_o | output | DATA_W | Last byte received |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command: 11 ACK/send, 10 NACK/stop, 0x no action |
| clr_data_i | input | 1 | Write-one clear of the data flag |
| clr_as_i | input | 1 | Write-one clear of the address/stop flag |
| clr_coll_i | input | 1 | Write-one clear of the collision flag |
| data_flag_o | output | 1 | Data byte event pending |
| as_flag_o | output | 1 | Address/stop/collision event pending |
| hold_o | output | 1 | Target is holding SCL low |
| rxack_o | output | 1 | Last acknowledge bit from the controller |
| coll_o | output | 1 | Collision flag |
| dir_o | output | 1 | Direction of the current transfer |

## Verification
Some properties are checked on every cycle: a set collision flag forces SDA to be released, and the target never pulls SDA low while idle. The direction bit changes only when an address byte completes. A valid command clears the event flags, a START clears the collision flag, a write-one clears it, and the data flag rises only on an SCL falling edge. The bench's bus transactions are needed to show the rest. These include the address match swept over all 128 addresses, stretching that holds SCL low against a controller that has released it, ACK/NACK responses, bytes shifted in and out MSB first, the silence after a collision, and the effect of the STOP enable.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    S_IDLE,   // not addressed
    S_ADDR,   // shifting in address byte
    S_AHOLD,  // address matched, waiting for software
    S_ASLOT,  // target owns the acknowledge slot
    S_RX,     // shifting in a data byte
    S_DHOLD,  // data received, waiting for software
    S_TX,     // shifting out a data byte
    S_TACK,   // sampling controller acknowledge
    S_THOLD,  // byte acknowledged, waiting for next byte
    S_WAIT    // out of the transfer until START/STOP
  } tgt_state_e;

  localparam int NFLAG  = 3;
  localparam int F_DATA = 0;
  localparam int F_AS   = 1;
  localparam int F_COLL = 2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;
  localparam int L_SDA  = 0;
  localparam int L_SCL  = 1;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] cur;
  logic [NLINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end

  assign sda_s    = cur[L_SDA];
  assign scl_rise = cur[L_SCL] & ~prev[L_SCL];
  assign scl_fall = ~cur[L_SCL] & prev[L_SCL];
  assign start_ev = cur[L_SCL] & prev[L_SCL] & prev[L_SDA] & ~cur[L_SDA];
  assign stop_ev  = cur[L_SCL] & prev[L_SCL] & ~prev[L_SDA] & cur[L_SDA];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm import i2c_tgt_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              stop_ie,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              cmd_go,
  input  logic              cmd_ack,
  input  logic              coll_q,
  output logic              set_df,
  output logic              set_as,
  output logic              set_coll,
  output logic              sda_low,
  output logic              dir,
  output logic              rxack,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-2:0] tx_sh;
  logic              go_on;
  logic              addr_hit;
  logic              own_slot;
  logic              addressed;

  assign addr_hit  = (sh[DATA_W-1:1] == own_addr);
  assign own_slot  = (state == S_TX) || (state == S_ASLOT);
  assign addressed = (state != S_IDLE) && (state != S_ADDR);

  always_comb begin
    set_df   = 1'b0;
    set_as   = 1'b0;
    set_coll = 1'b0;
    if (start_ev) begin
      set_as = 1'b0;
    end else if (stop_ev) begin
      set_as = stop_ie && addressed;
    end else begin
      if (scl_fall && state == S_ADDR && cnt == CNT_LAST && addr_hit) set_as = 1'b1;
      if (scl_rise && own_slot && !sda_low && !sda_s && !coll_q) begin
        set_coll = 1'b1;
        set_as   = 1'b1;
      end
      if (scl_fall && state == S_RX && cnt == CNT_LAST && !coll_q) set_df = 1'b1;
      if (scl_fall && state == S_TACK && !rxack) set_df = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx_sh   <= '0;
      go_on   <= 1'b0;
      sda_low <= 1'b0;
      dir     <= 1'b0;
      rxack   <= 1'b0;
      rx_data <= '0;
    end else if (start_ev) begin
      state   <= S_ADDR;
      cnt     <= '0;
      sda_low <= 1'b0;
    end else if (stop_ev) begin
      state   <= S_IDLE;
      sda_low <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state)
          S_ADDR, S_RX: begin
            sh  <= {sh[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          S_TX: begin
            cnt <= cnt + 1'b1;
            if (set_coll) begin
              state   <= S_WAIT;
              sda_low <= 1'b0;
            end
          end
          S_ASLOT: if (set_coll) state <= S_WAIT;
          S_TACK:  rxack <= sda_s;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state)
          S_ADDR: if (cnt == CNT_LAST) begin
            if (addr_hit) begin
              state <= S_AHOLD;
              dir   <= sh[0];
            end else begin
              state <= S_IDLE;
            end
          end
          S_ASLOT: begin
            cnt <= '0;
            if (!go_on) begin
              state   <= S_WAIT;
              sda_low <= 1'b0;
            end else if (dir) begin
              state   <= S_TX;
              tx_sh   <= tx_data[DATA_W-2:0];
              sda_low <= !tx_data[DATA_W-1] && !coll_q;
            end else begin
              state   <= S_RX;
              sda_low <= 1'b0;
            end
          end
          S_RX: if (cnt == CNT_LAST) begin
            rx_data <= sh;
            state   <= S_DHOLD;
          end
          S_TX: begin
            if (cnt == CNT_LAST) begin
              sda_low <= 1'b0;
              state   <= S_TACK;
            end else begin
              sda_low <= !tx_sh[DATA_W-2] && !coll_q;
              tx_sh   <= {tx_sh[DATA_W-3:0], 1'b0};
            end
          end
          S_TACK: state <= rxack ? S_WAIT : S_THOLD;
          default: ;
        endcase
      end
      if (cmd_go) begin
        case (state)
          S_AHOLD, S_DHOLD: begin
            go_on   <= cmd_ack;
            sda_low <= cmd_ack && !coll_q;
            state   <= S_ASLOT;
          end
          S_THOLD: begin
            if (cmd_ack) begin
              tx_sh   <= tx_data[DATA_W-2:0];
              sda_low <= !tx_data[DATA_W-1] && !coll_q;
              cnt     <= '0;
              state   <= S_TX;
            end else begin
              state <= S_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: an unaddressed target never pulls SDA
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_low);

  // R3: direction changes only when an address byte completes
  p_dir_only_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (state != S_ADDR) |=> $stable(dir));

  // R6: data flag events coincide with an SCL falling edge
  p_df_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    set_df |-> scl_fall);
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags import i2c_tgt_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_df,
  input  logic       set_as,
  input  logic       set_coll,
  input  logic       clr_df,
  input  logic       clr_as,
  input  logic       clr_coll,
  input  logic       cmd_wr,
  input  logic [1:0] cmd,
  input  logic       start_ev,
  output logic       cmd_go,
  output logic       df,
  output logic       as_f,
  output logic       coll
);
  logic [NFLAG-1:0] set_v, clr_v, auto_v, flag_v;

  // commands 2'b11 and 2'b10 are valid, 2'b0x are no action
  assign cmd_go = cmd_wr && cmd[1];

  assign set_v  = {set_coll, set_as, set_df};
  assign clr_v  = {clr_coll, clr_as, clr_df};
  assign auto_v = {start_ev, cmd_go, cmd_go};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= set_v[g] | (q & ~clr_v[g] & ~auto_v[g]);
    end
    assign flag_v[g] = q;
  end

  assign df   = flag_v[F_DATA];
  assign as_f = flag_v[F_AS];
  assign coll = flag_v[F_COLL];

  // R5: a valid command clears both event flags
  p_cmd_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && !set_df && !set_as) |=> (!df && !as_f));

  // R9: write-one clear of the collision flag
  p_w1c_coll_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_coll && !set_coll) |=> !coll);

  // R11: START clears the collision flag
  p_start_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (start_ev && !set_coll) |=> !coll);
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch import i2c_tgt_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic [DATA_W-2:0] own_addr_i,
  input  logic              stop_ie_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              cmd_wr_i,
  input  logic [1:0]        cmd_i,
  input  logic              clr_data_i,
  input  logic              clr_as_i,
  input  logic              clr_coll_i,
  output logic              data_flag_o,
  output logic              as_flag_o,
  output logic              hold_o,
  output logic              rxack_o,
  output logic              coll_o,
  output logic              dir_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic set_df, set_as, set_coll, cmd_go;
  logic df, as_f, coll;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr_i), .stop_ie(stop_ie_i), .tx_data(tx_data_i),
    .cmd_go(cmd_go), .cmd_ack(cmd_i[0]), .coll_q(coll),
    .set_df(set_df), .set_as(set_as), .set_coll(set_coll),
    .sda_low(sda_low_o), .dir(dir_o), .rxack(rxack_o), .rx_data(rx_data_o)
  );

  i2c_tgt_flags u_flags (
    .clk(clk), .rst(rst), .set_df(set_df), .set_as(set_as),
    .set_coll(set_coll), .clr_df(clr_data_i), .clr_as(clr_as_i),
    .clr_coll(clr_coll_i), .cmd_wr(cmd_wr_i), .cmd(cmd_i),
    .start_ev(start_ev), .cmd_go(cmd_go), .df(df), .as_f(as_f), .coll(coll)
  );

  assign scl_low_o   = df | as_f;
  assign hold_o      = scl_low_o;
  assign data_flag_o = df;
  assign as_flag_o   = as_f;
  assign coll_o      = coll;

  // R10: a pending collision keeps SDA released
  p_coll_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    coll_o |-> !sda_low_o);
endmodule

// File: tb/i2c_tgt_stretch_tb_top.sv
module i2c_tgt_stretch_tb_top;
  localparam int DW = 8;
  localparam int Q  = 6;
  localparam logic [DW-2:0] OWN = 7'h2D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_low_o, sda_low_o;
  logic scl_line, sda_line;
  logic stop_ie = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic [DW-1:0] rx_data;
  logic cmd_wr = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic clr_d = 1'b0, clr_a = 1'b0, clr_c = 1'b0;
  logic df, asf, hold, rxack, coll, dir;
  int n_cmp = 0, n_bad = 0;

  assign scl_line = !(m_scl_low || scl_low_o);
  assign sda_line = !(m_sda_low || sda_low_o);

  i2c_tgt_stretch #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .own_addr_i(OWN),
    .stop_ie_i(stop_ie), .tx_data_i(tx_data), .rx_data_o(rx_data),
    .cmd_wr_i(cmd_wr), .cmd_i(cmd), .clr_data_i(clr_d), .clr_as_i(clr_a),
    .clr_coll_i(clr_c), .data_flag_o(df), .as_flag_o(asf), .hold_o(hold),
    .rxack_o(rxack), .coll_o(coll), .dir_o(dir)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_scl;
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda_low = 1'b0; waitc(Q);
    release_scl;      waitc(Q);
    m_sda_low = 1'b1; waitc(Q);
    m_scl_low = 1'b1; waitc(Q);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; waitc(Q);
    release_scl;      waitc(Q);
    m_sda_low = 1'b0; waitc(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = !b; waitc(Q);
    release_scl;    waitc(2*Q);
    m_scl_low = 1'b1; waitc(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; waitc(Q);
    release_scl;      waitc(Q);
    b = sda_line;     waitc(Q);
    m_scl_low = 1'b1; waitc(Q);
  endtask

  task automatic put_byte(input logic [DW-1:0] v);
    for (int i = DW-1; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic get_bits(input int n, output logic [DW-1:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin
      get_bit(b);
      v = {v[DW-2:0], b};
    end
  endtask

  task automatic do_cmd(input logic [1:0] c);
    @(negedge clk); cmd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0; cmd = 2'b00;
    waitc(2);
  endtask

  task automatic do_clr(input logic d, input logic a, input logic c);
    @(negedge clk); clr_d = d; clr_a = a; clr_c = c;
    @(negedge clk); clr_d = 1'b0; clr_a = 1'b0; clr_c = 1'b0;
    waitc(2);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary;
    $finish;
  end

  initial begin
    logic b;
    logic [DW-1:0] v;
    waitc(5);
    rst = 1'b0;
    waitc(3);
    // R1 reset state
    chk("R1", {scl_low_o, sda_low_o, df, asf, hold, rxack, coll, dir}, 8'h00);

    // R2 R3 R4 R5: sweep every address with a write bit
    for (int a = 0; a < 128; a++) begin
      bus_start;
      put_byte({a[6:0], 1'b0});
      chk("R2", asf, (a[6:0] == OWN));
      chk("R4", hold, (a[6:0] == OWN));
      if (a[6:0] == OWN) begin
        chk("R3", dir, 0);
        do_cmd(2'b10);
        chk("R5", {asf, hold}, 2'b00);
        get_bit(b);
        chk("R5", b, 1);
      end else begin
        get_bit(b);
        chk("R2", b, 1);
      end
      bus_stop;
      chk("R12", asf, 0);
    end

    // controller write: R5 R6 R4 R9 R12
    bus_start;
    put_byte({OWN, 1'b0});
    chk("R2", asf, 1);
    do_cmd(2'b00);
    chk("R5", {asf, hold}, 2'b11);
    do_cmd(2'b01);
    chk("R5", {asf, hold}, 2'b11);
    do_cmd(2'b11);
    get_bit(b);
    chk("R5", b, 0);
    chk("R3", dir, 0);
    put_byte(8'hA5);
    chk("R6", {df, asf}, 2'b10);
    chk("R6", rx_data, 8'hA5);
    m_scl_low = 1'b0;
    waitc(20);
    chk("R4", scl_line, 0);
    chk("R4", hold, 1);
    m_scl_low = 1'b1;
    do_cmd(2'b11);
    chk("R4", hold, 0);
    get_bit(b);
    chk("R6", b, 0);
    put_byte(8'h3C);
    chk("R6", rx_data, 8'h3C);
    chk("R6", df, 1);
    do_clr(1'b1, 1'b0, 1'b0);
    chk("R9", {df, hold}, 2'b00);
    get_bit(b);
    chk("R9", b, 1);
    bus_stop;
    chk("R12", asf, 0);

    // controller read: R3 R7 R8 R12
    stop_ie = 1'b1;
    bus_start;
    put_byte({OWN, 1'b1});
    chk("R3", dir, 1);
    tx_data = 8'hC3;
    do_cmd(2'b11);
    get_bit(b);
    chk("R5", b, 0);
    get_bits(8, v);
    chk("R7", v, 8'hC3);
    put_bit(1'b0);
    chk("R8", rxack, 0);
    chk("R7", {df, hold}, 2'b11);
    tx_data = 8'h5E;
    do_cmd(2'b11);
    get_bits(8, v);
    chk("R7", v, 8'h5E);
    put_bit(1'b1);
    chk("R8", rxack, 1);
    chk("R7", {df, hold}, 2'b00);
    get_bits(8, v);
    chk("R7", v, 8'hFF);
    put_bit(1'b1);
    bus_stop;
    chk("R12", asf, 1);
    chk("R4", hold, 1);
    do_clr(1'b0, 1'b1, 1'b0);
    chk("R9", {asf, hold}, 2'b00);

    // collision cleared by write-one: R10 R9
    bus_start;
    put_byte({OWN, 1'b1});
    tx_data = 8'h80;
    do_cmd(2'b11);
    get_bit(b);
    put_bit(1'b0);
    chk("R10", {coll, asf, hold}, 3'b111);
    do_clr(1'b0, 1'b1, 1'b1);
    chk("R9", {coll, asf}, 2'b00);
    get_bits(7, v);
    chk("R10", v, 8'h7F);
    put_bit(1'b1);
    bus_stop;
    do_clr(1'b0, 1'b1, 1'b0);

    // collision cleared by repeated START: R10 R11
    bus_start;
    put_byte({OWN, 1'b1});
    do_cmd(2'b11);
    get_bit(b);
    put_bit(1'b0);
    chk("R10", coll, 1);
    do_clr(1'b0, 1'b1, 1'b0);
    get_bits(7, v);
    chk("R10", v, 8'h7F);
    chk("R10", coll, 1);
    put_bit(1'b1);
    bus_start;
    chk("R11", coll, 0);
    put_byte({OWN, 1'b0});
    chk("R11", {asf, dir}, 2'b10);
    do_cmd(2'b10);
    get_bit(b);
    chk("R11", b, 1);
    bus_stop;
    do_clr(1'b0, 1'b1, 1'b0);
    chk("R4", hold, 0);

    summary;
    $finish;
  end
endmodule